// File: doc/BRIEF.md
# Posted register write synchronizer

This block carries host register writes from a fast interface clock into a timer core that runs on a separate, slower and unrelated functional clock. Each of the timer's synchronized registers has its own toggle request/acknowledge crossing with two-flop synchronizers in both directions. The value written by the host is held on the interface side and sampled by the functional side once the request edge arrives. The functional side then returns an acknowledge edge.

Two write modes exist, selected by bit 0 of an interface control register. In non-posted mode the host bus is stalled until the value has landed in the functional domain. In posted mode the write is accepted at once, and a per-register bit in a pending status register tracks the transfer until its acknowledge returns. The control register also starts a soft reset, and a system status register reports when that reset has completed.

The host port is a simple valid/ready register port. Registers 0 to NSYNC-1 are the synchronized registers. Address NSYNC is the interface control register, NSYNC+1 is the pending status register and NSYNC+2 is the system status register.

Top module: `posted_wr_sync`

## Requirements
- R1: After the hardware reset, the pending status register (address NSYNC+1) reads 0, the interface control register (address NSYNC) reads 0 (non-posted), the system status register (address NSYNC+2) reads 1, and every functional-domain register value is 0.
- R2: With interface control bit 0 set (posted mode), a write to a synchronized register has h_ready high in the same cycle as h_valid, with no wait cycles.
- R3: Bit i of the pending status register is set from the cycle after a write to synchronized register i until that register's functional-domain value equals the written data. The bit clears only after the value has landed.
- R4: In posted mode, a write to a register whose pending bit is set is accepted but discarded, and the earlier value is the one that lands.
- R5: In non-posted mode, h_ready for a synchronized-register write stays low until the functional-domain value equals the written data. If the register is still pending from an earlier posted write, the new write waits for it and is not lost.
- R6: A read of a synchronized register whose pending bit is set returns h_err = 1 and data 0. Otherwise it returns the last accepted value with h_err = 0.
- R7: Writing the interface control register with bit 1 set (for example 0x06) starts a soft reset. The system status register reads 0 until the reset completes and 1 afterwards. Synchronized-register writes stall while the reset runs. Afterwards posted mode is off and every register reads 0 in both domains.
- R8: Pending transfers to different registers proceed independently. Two posted writes issued back to back to different registers both show pending, and both land.
- R9: The interface control register takes effect directly. A write to it is acknowledged at once, is read back on the next access, and sets no pending bit.
- R10: When software waits for a register's pending bit to clear before writing that register again, every one of a long series of posted writes lands in the functional domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| iclk | input | 1 | Interface (host) clock |
| fclk | input | 1 | Functional clock, asynchronous to iclk and slower than it |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| h_valid | input | 1 | Host access request |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | AW | Register address |
| h_wdata | input | DW | Write data |
| h_ready | output | 1 | Access completes in a cycle where h_valid and h_ready are both high |
| h_rdata | output | DW | Read data, valid while h_ready is high on a read |
| h_err | output | 1 | Read hit a register with a write in flight |
| f_regs_o | output | NSYNC*DW | Functional-domain register values, register i at bits i*DW upward |

## Verification
The hardest state to reach is a non-posted write arriving while the same register still has a posted transfer in flight. The stimulus reaches it by posting a write, switching the mode off through the control register, and writing the same register again, all within the round-trip time. A second hard case is a synchronized-register write issued right after a soft reset starts. The bench reads the system status register straight after the reset request and then issues that write. This write must stall through the whole reset handshake and then land in non-posted mode, while the other registers read as cleared.

// File: rtl/pws_pkg.sv
package pws_pkg;
   localparam int IFC_POSTED_BIT = 0;
   localparam int IFC_SRST_BIT   = 1;

   typedef enum logic [0:0] {HC_IDLE, HC_WAIT} hc_state_e;
   typedef enum logic [1:0] {SR_IDLE, SR_DRAIN, SR_HANDSHAKE} sr_state_e;
endpackage

// File: rtl/pws_sync.sv
module pws_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pws_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pws_reg_xfer.sv
module pws_reg_xfer #(
   parameter int DW     = 16,
   parameter int STAGES = 2
) (
   input  logic          iclk,
   input  logic          fclk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          clear_i,
   input  logic          fclear_i,
   input  logic [DW-1:0] wdata_i,
   output logic          pend_o,
   output logic [DW-1:0] shadow_o,
   output logic [DW-1:0] fval_o
);
   logic          req_t, req_s, ack_t, ack_s;
   logic [DW-1:0] hold;

   // interface side: capture and raise request edge
   always_ff @(posedge iclk or negedge rst_n) begin
      if (!rst_n) begin
         req_t <= 1'b0;
         hold  <= '0;
      end else if (load_i && !pend_o) begin
         hold  <= wdata_i;
         req_t <= ~req_t;
      end else if (clear_i) begin
         hold  <= '0;
      end
   end

   assign pend_o   = req_t ^ ack_s;
   assign shadow_o = hold;

   pws_sync #(.STAGES(STAGES)) u_req_sync (
      .clk(fclk), .rst_n(rst_n), .d(req_t), .q(req_s)
   );

   // functional side: sample held value and return acknowledge edge
   always_ff @(posedge fclk or negedge rst_n) begin
      if (!rst_n) begin
         ack_t  <= 1'b0;
         fval_o <= '0;
      end else if (req_s != ack_t) begin
         fval_o <= hold;
         ack_t  <= req_s;
      end else if (fclear_i) begin
         fval_o <= '0;
      end
   end

   pws_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk(iclk), .rst_n(rst_n), .d(ack_t), .q(ack_s)
   );

   assert_launch_pends_R3: assert property (@(posedge iclk) disable iff (!rst_n)
      (load_i && !pend_o) |=> pend_o);

   assert_drop_keeps_hold_R4: assert property (@(posedge iclk) disable iff (!rst_n)
      (load_i && pend_o) |=> $stable(hold));
endmodule

// File: rtl/pws_host_ctrl.sv
module pws_host_ctrl
   import pws_pkg::*;
#(
   parameter int DW    = 16,
   parameter int NSYNC = 10,
   parameter int AW    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                h_valid,
   input  logic                h_write,
   input  logic [AW-1:0]       h_addr,
   input  logic [DW-1:0]       h_wdata,
   output logic                h_ready,
   output logic [DW-1:0]       h_rdata,
   output logic                h_err,
   input  logic [NSYNC-1:0]    pend_i,
   input  logic [NSYNC*DW-1:0] shadow_i,
   input  logic                srst_ack_s,
   output logic [NSYNC-1:0]    load_o,
   output logic                clear_o,
   output logic                srst_req_t
);
   localparam int IW = $clog2(NSYNC);
   localparam logic [AW-1:0] A_IFC  = AW'(NSYNC);
   localparam logic [AW-1:0] A_PEND = AW'(NSYNC + 1);
   localparam logic [AW-1:0] A_SYS  = AW'(NSYNC + 2);

   hc_state_e      hc_q;
   sr_state_e      sr_q;
   logic           posted_q;
   logic           busy;
   logic           is_sync, launch, pend_sel;
   logic [IW-1:0]  idx;
   logic [DW-1:0]  shadow_sel;

   assign busy    = (sr_q != SR_IDLE);
   assign is_sync = (h_addr < A_IFC);
   assign idx     = h_addr[IW-1:0];

   always_comb begin
      pend_sel   = 1'b0;
      shadow_sel = '0;
      for (int i = 0; i < NSYNC; i++) begin
         if (idx == IW'(i)) begin
            pend_sel   = pend_i[i];
            shadow_sel = shadow_i[i*DW +: DW];
         end
      end
   end

   always_comb begin
      h_ready = 1'b0;
      h_rdata = '0;
      h_err   = 1'b0;
      launch  = 1'b0;
      if (h_valid) begin
         if (!h_write) begin
            h_ready = 1'b1;
            if (is_sync) begin
               h_err   = pend_sel;
               h_rdata = pend_sel ? '0 : shadow_sel;
            end else if (h_addr == A_IFC) begin
               h_rdata = DW'(posted_q);
            end else if (h_addr == A_PEND) begin
               h_rdata = DW'(pend_i);
            end else if (h_addr == A_SYS) begin
               h_rdata = DW'(!busy);
            end
         end else if (is_sync) begin
            if (!busy) begin
               if (posted_q) begin
                  h_ready = 1'b1;
                  launch  = 1'b1;
               end else if (hc_q == HC_WAIT) begin
                  h_ready = !pend_sel;
               end else begin
                  launch = !pend_sel;
               end
            end
         end else begin
            h_ready = 1'b1;
         end
      end
   end

   always_comb begin
      for (int i = 0; i < NSYNC; i++) load_o[i] = launch && (idx == IW'(i));
   end

   assign clear_o = (sr_q == SR_DRAIN) && (pend_i == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc_q <= HC_IDLE;
      end else if (hc_q == HC_IDLE) begin
         if (launch && !posted_q) hc_q <= HC_WAIT;
      end else if (h_valid && h_ready) begin
         hc_q <= HC_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         posted_q   <= 1'b0;
         sr_q       <= SR_IDLE;
         srst_req_t <= 1'b0;
      end else begin
         if (h_valid && h_write && h_addr == A_IFC) begin
            posted_q <= h_wdata[IFC_POSTED_BIT];
            if (h_wdata[IFC_SRST_BIT] && !busy) sr_q <= SR_DRAIN;
         end
         case (sr_q)
            SR_DRAIN: if (clear_o) begin
               srst_req_t <= ~srst_req_t;
               sr_q       <= SR_HANDSHAKE;
            end
            SR_HANDSHAKE: if (srst_ack_s == srst_req_t) begin
               posted_q <= 1'b0;
               sr_q     <= SR_IDLE;
            end
            default: ;
         endcase
      end
   end

   assert_posted_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (h_valid && h_write && is_sync && posted_q && !busy) |-> h_ready);

   assert_nonposted_landed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (h_valid && h_write && is_sync && !posted_q && h_ready) |-> !pend_sel);

   assert_read_pending_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (h_valid && !h_write && is_sync && pend_sel) |-> (h_err && h_rdata == '0));

   assert_srst_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && h_valid && h_write && is_sync) |-> !h_ready);

   assert_srst_posted_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !posted_q);
endmodule

// File: rtl/posted_wr_sync.sv
module posted_wr_sync #(
   parameter int DW     = 16,
   parameter int NSYNC  = 10,
   parameter int STAGES = 2,
   parameter int AW     = $clog2(NSYNC + 3)
) (
   input  logic                iclk,
   input  logic                fclk,
   input  logic                rst_n,
   input  logic                h_valid,
   input  logic                h_write,
   input  logic [AW-1:0]       h_addr,
   input  logic [DW-1:0]       h_wdata,
   output logic                h_ready,
   output logic [DW-1:0]       h_rdata,
   output logic                h_err,
   output logic [NSYNC*DW-1:0] f_regs_o
);
   generate
      if (NSYNC < 2)              begin : g_bad_nsync $error("NSYNC must be at least 2"); end
      if (DW < NSYNC || DW < 2)   begin : g_bad_dw    $error("DW must hold the pending bits"); end
      if (AW < $clog2(NSYNC + 3)) begin : g_bad_aw    $error("AW too narrow for the map"); end
   endgenerate

   logic [NSYNC-1:0]    pend, load;
   logic [NSYNC*DW-1:0] shadow;
   logic                clear_i, fclear;
   logic                srst_req_t, srst_req_s, srst_ack_t, srst_ack_s;

   pws_host_ctrl #(.DW(DW), .NSYNC(NSYNC), .AW(AW)) u_host (
      .clk(iclk), .rst_n(rst_n),
      .h_valid(h_valid), .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata),
      .h_ready(h_ready), .h_rdata(h_rdata), .h_err(h_err),
      .pend_i(pend), .shadow_i(shadow), .srst_ack_s(srst_ack_s),
      .load_o(load), .clear_o(clear_i), .srst_req_t(srst_req_t)
   );

   genvar g;
   generate
      for (g = 0; g < NSYNC; g++) begin : g_reg
         pws_reg_xfer #(.DW(DW), .STAGES(STAGES)) u_xfer (
            .iclk(iclk), .fclk(fclk), .rst_n(rst_n),
            .load_i(load[g]), .clear_i(clear_i), .fclear_i(fclear),
            .wdata_i(h_wdata),
            .pend_o(pend[g]), .shadow_o(shadow[g*DW +: DW]),
            .fval_o(f_regs_o[g*DW +: DW])
         );
      end
   endgenerate

   // soft reset crossing
   pws_sync #(.STAGES(STAGES)) u_srst_req (
      .clk(fclk), .rst_n(rst_n), .d(srst_req_t), .q(srst_req_s)
   );

   assign fclear = srst_req_s ^ srst_ack_t;

   always_ff @(posedge fclk or negedge rst_n) begin
      if (!rst_n) srst_ack_t <= 1'b0;
      else        srst_ack_t <= srst_req_s;
   end

   pws_sync #(.STAGES(STAGES)) u_srst_ack (
      .clk(iclk), .rst_n(rst_n), .d(srst_ack_t), .q(srst_ack_s)
   );

   assert_srst_after_drain_R7: assert property (@(posedge iclk) disable iff (!rst_n)
      clear_i |-> (pend == '0));
endmodule

// File: tb/tb_posted_wr_sync.sv
module tb_posted_wr_sync;
   localparam int DW = 16, NSYNC = 10, AW = 4;
   localparam logic [AW-1:0] A_IFC = 4'd10, A_PEND = 4'd11, A_SYS = 4'd12;

   // entry: {posted, reg index, data}
   localparam logic [20:0] VEC [0:7] = '{
      {1'b0, 4'd0, 16'h1234}, {1'b1, 4'd1, 16'h00FF},
      {1'b0, 4'd3, 16'hABCD}, {1'b1, 4'd6, 16'h8001},
      {1'b0, 4'd8, 16'h7FFE}, {1'b1, 4'd9, 16'h0001},
      {1'b0, 4'd2, 16'hFFFF}, {1'b1, 4'd4, 16'h3C3C}};

   logic iclk = 0, fclk = 0, rst_n = 0;
   logic h_valid = 0, h_write = 0;
   logic [AW-1:0] h_addr = '0;
   logic [DW-1:0] h_wdata = '0;
   logic h_ready, h_err;
   logic [DW-1:0] h_rdata;
   logic [NSYNC*DW-1:0] f_regs_o;

   int n_cmp = 0, n_mis = 0;
   bit done = 0;
   logic [DW-1:0] rd, fs, vdat;
   logic er, vmode;
   logic [3:0] vreg;
   int waits;

   always #10 iclk = ~iclk;
   always #47 fclk = ~fclk;

   posted_wr_sync #(.DW(DW), .NSYNC(NSYNC), .STAGES(2), .AW(AW)) dut (
      .iclk(iclk), .fclk(fclk), .rst_n(rst_n),
      .h_valid(h_valid), .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata),
      .h_ready(h_ready), .h_rdata(h_rdata), .h_err(h_err), .f_regs_o(f_regs_o)
   );

   function automatic logic [DW-1:0] fv(input int i);
      return f_regs_o[i*DW +: DW];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge iclk);
      h_valid = 1; h_write = w; h_addr = a; h_wdata = d;
      #1;
      waits = 0;
      while (!h_ready && waits < 5000) begin
         @(negedge iclk); #1;
         waits++;
      end
      rd = h_rdata; er = h_err;
      fs = (a < 4'd10) ? fv(int'(a)) : '0;
      @(posedge iclk); #1;
      h_valid = 0; h_write = 0;
   endtask

   task automatic drain();
      for (int k = 0; k < 2000; k++) begin
         bus(0, A_PEND, 0);
         if (rd == 0) break;
      end
   endtask

   initial begin
      repeat (200000) @(posedge iclk);
      if (!done) begin
         n_cmp++; n_mis++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge iclk);
      rst_n = 1;

      // R1 reset state
      bus(0, A_PEND, 0); chk("R1 pending", rd, 0);
      bus(0, A_IFC, 0);  chk("R1 ifctrl", rd, 0);
      bus(0, A_SYS, 0);  chk("R1 sysstat", rd, 1);
      chk("R1 fregs zero", (f_regs_o == '0), 1);

      // table walk
      for (int k = 0; k < 8; k++) begin
         {vmode, vreg, vdat} = VEC[k];
         bus(1, A_IFC, DW'(vmode));
         bus(1, vreg, vdat);
         if (vmode) begin
            chk("R2 posted no wait", waits, 0);
            bus(0, A_PEND, 0);
            chk("R3 pending set", rd[vreg], 1);
         end else begin
            chk("R5 landed before ready", fs, vdat);
            bus(0, A_PEND, 0);
            chk("R5 none pending after ready", rd[vreg], 0);
         end
         drain();
         chk("R3 value landed", fv(int'(vreg)), vdat);
         bus(0, vreg, 0);
         chk("R6 readback", {er, rd}, {1'b0, vdat});
      end

      // R4 second posted write while pending is lost
      bus(1, A_IFC, 1);
      bus(1, 4'd2, 16'hAAAA);
      bus(1, 4'd2, 16'hBBBB);
      chk("R4 second write acked", waits, 0);
      drain();
      chk("R4 first value kept", fv(2), 16'hAAAA);
      bus(0, 4'd2, 0); chk("R4 readback", rd, 16'hAAAA);

      // R6 read while pending
      bus(1, 4'd5, 16'h5555);
      bus(0, 4'd5, 0);
      chk("R6 pending read err", {er, rd}, {1'b1, 16'h0000});
      drain();
      bus(0, 4'd5, 0);
      chk("R6 read after land", {er, rd}, {1'b0, 16'h5555});

      // R8 independent registers
      bus(1, 4'd0, 16'h0F0F);
      bus(1, 4'd9, 16'hF0F0);
      bus(0, A_PEND, 0);
      chk("R8 both pending", rd & 16'h0201, 16'h0201);
      drain();
      chk("R8 both landed", {fv(0), fv(9)}, {16'h0F0F, 16'hF0F0});

      // R9 interface control direct
      bus(1, A_IFC, 0);
      chk("R9 direct ack", waits, 0);
      bus(0, A_IFC, 0); chk("R9 readback", rd, 0);
      bus(0, A_PEND, 0); chk("R9 no pending", rd, 0);
      bus(1, A_IFC, 1);
      bus(0, A_IFC, 0); chk("R9 readback set", rd, 1);

      // R5 non-posted behind a posted transfer on the same register
      bus(1, 4'd4, 16'h1111);
      bus(1, A_IFC, 0);
      bus(1, 4'd4, 16'h2222);
      chk("R5 stalled", (waits > 0), 1);
      chk("R5 not lost", fs, 16'h2222);
      bus(0, 4'd4, 0); chk("R5 readback", rd, 16'h2222);

      // R10 honour pending bits over many writes
      bus(1, A_IFC, 1);
      for (int k = 0; k < 20; k++) begin
         bus(1, 4'd7, DW'(k * 16'h0301 + 7));
         drain();
         chk("R10 every write lands", fv(7), DW'(k * 16'h0301 + 7));
      end

      // R7 soft reset
      bus(1, A_IFC, 16'h0006);
      bus(0, A_SYS, 0); chk("R7 busy status", rd, 0);
      bus(1, 4'd1, 16'h7777);
      chk("R7 write stalled", (waits > 0), 1);
      chk("R7 stalled write landed", fs, 16'h7777);
      bus(0, A_SYS, 0); chk("R7 done status", rd, 1);
      bus(0, A_IFC, 0); chk("R7 posted off", rd, 0);
      chk("R7 functional cleared", {fv(7), fv(4), fv(0)}, 48'h0);
      bus(0, 4'd9, 0); chk("R7 shadow cleared", rd, 0);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end
endmodule